// File: doc/BRIEF.md
# NAND Host Bus Bridge

This block lets a processor with a 16-bit bus drive an 8-bit NAND flash device through five byte-addressed registers. A control register (here called the mode register) sets the chip-enable, command-latch and address-latch lines and gates write traffic. A data port turns each host access into NAND byte cycles. A 16-bit access becomes two byte cycles, low byte first. An 8-bit access becomes one byte cycle, and this is how command and address bytes are sent.

Each byte cycle drives data, or waits for it, one clock before the read or write strobe goes low. The strobe stays low for `STROBE_CLKS` clocks, and the line is then held for one more clock. The host is stalled on `host_wait` until every byte cycle of the access has finished.

The block synchronises the device's ready/busy line and shows it in a status register. It latches each busy-to-ready transition into an interrupt status bit. The host can clear that bit and can mask it.

Top module: `nand_host_bridge`

## Requirements
- R1: After reset, chip enable is inactive (`nand_ce_n`=1), `nand_cle`, `nand_ale`, `nand_dq_oe`, `host_wait` and `host_irq` are 0, both strobes are high, and the mode register reads 0x00.
- R2: The mode register at address 4 reads back as written. Bit 4 drives chip enable (`nand_ce_n` = not bit 4), bit 0 drives `nand_cle` and bit 1 drives `nand_ale`. Thus 0x95 gives command cycles, 0x96 gives address cycles, 0x94 gives plain data cycles and 0x00 gives standby.
- R3: A 16-bit write to the data port (address 0) makes two write cycles, `host_wdata[7:0]` first and `host_wdata[15:8]` second. In each cycle `nand_we_n` is low for exactly `STROBE_CLKS` clocks, `nand_dq_oe` is high from one clock before the strobe to one clock after it, and the two strobes are never low together.
- R4: An 8-bit write to the data port makes exactly one write cycle carrying `host_wdata[7:0]`.
- R5: While mode bit 7 is 0, a data-port write makes no NAND cycle and raises no `host_wait`.
- R6: A 16-bit data-port read makes two read cycles and returns the first byte in bits 7:0 and the second in bits 15:8. An 8-bit read returns its single byte in bits 7:0 with bits 15:8 at zero.
- R7: `host_wait` is high from the clock after a data-port access is accepted until its last byte cycle ends. Requests made while `host_wait` is high are ignored, and the latch and enable lines do not change during a transfer.
- R8: Status register bit 7 (address 5) reads 1 while `nand_rb` is low (busy) and 0 when it is high (ready). The value is taken after a `SYNC_STAGES`-flop synchroniser.
- R9: Interrupt status bit 0 (address 6) is set by a low-to-high transition of `nand_rb`. A high-to-low transition does not set it. Writing 1s to address 6 clears the matching bits, so 0x0F clears them all.
- R10: `host_irq` is the OR of interrupt status ANDed with the mask register (address 7). Writing 0x81 enables the ready interrupt and writing 0x00 disables it. The output stays high until the status bit is cleared or masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | One-cycle access request; taken only while host_wait is low |
| host_we | input | 1 | 1 = write, 0 = read |
| host_wide | input | 1 | Data port only: 1 = 16-bit access, 0 = 8-bit |
| host_addr | input | 3 | Register byte address |
| host_wdata | input | 16 | Write data; registers use bits 7:0 |
| host_rdata | output | 16 | Read data, valid once the access has completed |
| host_wait | output | 1 | Host stall while NAND byte cycles run |
| host_irq | output | 1 | Masked ready interrupt |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Byte driven to the device |
| nand_dq_oe | output | 1 | Output enable for nand_dq_out |
| nand_dq_in | input | 8 | Byte returned by the device |
| nand_rb | input | 1 | Ready/busy from the device, 1 = ready |

## Verification
A corrupted byte-sequencer state shows at the pins within one strobe period. The result is a write strobe of the wrong width, a data bus released during the strobe, or bytes arriving at the device in the wrong order. The bench's write monitor reports each of these at the strobe's rising edge. A fault in the transfer controller shows as `host_wait` falling too early, never falling, or returning swapped or stale halves of a read word, and the fault is visible when that access completes. A damaged edge detector or mask shows on `host_irq` and in the status readback within `SYNC_STAGES`+2 clocks of the ready transition.

// File: rtl/nand_bridge_pkg.sv
package nand_bridge_pkg;
  localparam int ADDR_W = 3;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int ISR_W  = 4;

  localparam logic [ADDR_W-1:0] ADDR_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_MODE = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_ISR  = 3'd6;
  localparam logic [ADDR_W-1:0] ADDR_IMR  = 3'd7;

  localparam int MODE_CLE = 0;
  localparam int MODE_ALE = 1;
  localparam int MODE_CE  = 4;
  localparam int MODE_WEN = 7;

  typedef enum logic [1:0] {CYC_IDLE, CYC_SETUP, CYC_PULSE, CYC_HOLD} cyc_state_t;
  typedef enum logic [1:0] {XF_IDLE, XF_LO, XF_HI} xf_state_t;
endpackage

// File: rtl/nand_byte_cycle.sv
module nand_byte_cycle
  import nand_bridge_pkg::*;
#(
  parameter int STROBE_CLKS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              is_read,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic [BYTE_W-1:0] dq_in,
  output logic              we_n,
  output logic              re_n,
  output logic              dq_oe,
  output logic [BYTE_W-1:0] dq_out,
  output logic [BYTE_W-1:0] rbyte,
  output logic              done
);
  localparam int CNT_W = (STROBE_CLKS > 1) ? $clog2(STROBE_CLKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STROBE_CLKS - 1);

  cyc_state_t       state;
  logic             dir_rd;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= CYC_IDLE;
      dir_rd <= 1'b0;
      cnt    <= '0;
      we_n   <= 1'b1;
      re_n   <= 1'b1;
      dq_oe  <= 1'b0;
      dq_out <= '0;
      rbyte  <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        CYC_IDLE: begin
          if (start) begin
            state  <= CYC_SETUP;
            dir_rd <= is_read;
            dq_out <= wbyte;
            dq_oe  <= ~is_read;
          end
        end
        CYC_SETUP: begin
          state <= CYC_PULSE;
          cnt   <= CNT_LOAD;
          if (dir_rd) re_n <= 1'b0;
          else        we_n <= 1'b0;
        end
        CYC_PULSE: begin
          if (cnt == '0) begin
            we_n  <= 1'b1;
            re_n  <= 1'b1;
            state <= CYC_HOLD;
            if (dir_rd) rbyte <= dq_in;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          state <= CYC_IDLE;
          dq_oe <= 1'b0;
          done  <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/nand_xfer_ctrl.sv
module nand_xfer_ctrl
  import nand_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              go_read,
  input  logic              go_wide,
  input  logic [WORD_W-1:0] go_wdata,
  input  logic              cyc_done,
  input  logic [BYTE_W-1:0] cyc_rbyte,
  output logic              cyc_start,
  output logic              cyc_read,
  output logic [BYTE_W-1:0] cyc_wbyte,
  output logic              busy,
  output logic [WORD_W-1:0] word
);
  xf_state_t         state;
  logic              wide_q;
  logic [BYTE_W-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= XF_IDLE;
      cyc_start <= 1'b0;
      cyc_read  <= 1'b0;
      cyc_wbyte <= '0;
      busy      <= 1'b0;
      wide_q    <= 1'b0;
      hi_q      <= '0;
      word      <= '0;
    end else begin
      cyc_start <= 1'b0;
      case (state)
        XF_IDLE: begin
          if (go) begin
            busy      <= 1'b1;
            cyc_start <= 1'b1;
            cyc_read  <= go_read;
            wide_q    <= go_wide;
            cyc_wbyte <= go_wdata[BYTE_W-1:0];
            hi_q      <= go_wdata[WORD_W-1:BYTE_W];
            state     <= XF_LO;
          end
        end
        XF_LO: begin
          if (cyc_done) begin
            if (cyc_read) word <= {{BYTE_W{1'b0}}, cyc_rbyte};
            if (wide_q) begin
              cyc_start <= 1'b1;
              cyc_wbyte <= hi_q;
              state     <= XF_HI;
            end else begin
              busy  <= 1'b0;
              state <= XF_IDLE;
            end
          end
        end
        default: begin
          if (cyc_done) begin
            if (cyc_read) word[WORD_W-1:BYTE_W] <= cyc_rbyte;
            busy  <= 1'b0;
            state <= XF_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/nand_ready_irq.sv
module nand_ready_irq
  import nand_bridge_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rb,
  input  logic              clr_we,
  input  logic [ISR_W-1:0]  clr_bits,
  input  logic              mask_we,
  input  logic [BYTE_W-1:0] mask_din,
  output logic              busy,
  output logic [ISR_W-1:0]  isr,
  output logic [BYTE_W-1:0] mask,
  output logic              irq
);
  logic [SYNC_STAGES:0] sh;
  logic                 rise;
  logic [ISR_W-1:0]     src;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[SYNC_STAGES-1:0], rb};
  end

  assign busy = ~sh[SYNC_STAGES-1];
  assign rise = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];
  assign src  = ISR_W'(rise);

  for (genvar i = 0; i < ISR_W; i++) begin : g_isr
    always_ff @(posedge clk) begin
      if (rst)                        isr[i] <= 1'b0;
      else if (src[i])                isr[i] <= 1'b1;
      else if (clr_we && clr_bits[i]) isr[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '0;
      irq  <= 1'b0;
    end else begin
      if (mask_we) mask <= mask_din;
      irq <= |(isr & mask[ISR_W-1:0]);
    end
  end
endmodule

// File: rtl/nand_host_bridge.sv
module nand_host_bridge
  import nand_bridge_pkg::*;
#(
  parameter int STROBE_CLKS = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_req,
  input  logic        host_we,
  input  logic        host_wide,
  input  logic [2:0]  host_addr,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  output logic        host_wait,
  output logic        host_irq,
  output logic        nand_ce_n,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic        nand_re_n,
  output logic [7:0]  nand_dq_out,
  output logic        nand_dq_oe,
  input  logic [7:0]  nand_dq_in,
  input  logic        nand_rb
);
  logic              acc, data_go, wr_acc;
  logic [BYTE_W-1:0] mode_q, reg_mux, reg_rd_q;
  logic              sel_data_q;
  logic              xf_busy, cyc_start, cyc_read, cyc_done;
  logic [BYTE_W-1:0] cyc_wbyte, cyc_rbyte;
  logic [WORD_W-1:0] xf_word;
  logic              rdy_busy;
  logic [ISR_W-1:0]  isr;
  logic [BYTE_W-1:0] imr;

  assign acc     = host_req & ~xf_busy;
  assign wr_acc  = acc & host_we;
  assign data_go = acc & (host_addr == ADDR_DATA) & (~host_we | mode_q[MODE_WEN]);

  always_comb begin
    case (host_addr)
      ADDR_MODE: reg_mux = mode_q;
      ADDR_STAT: reg_mux = {rdy_busy, {(BYTE_W-1){1'b0}}};
      ADDR_ISR:  reg_mux = {{(BYTE_W-ISR_W){1'b0}}, isr};
      ADDR_IMR:  reg_mux = imr;
      default:   reg_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= '0;
      reg_rd_q   <= '0;
      sel_data_q <= 1'b0;
    end else begin
      if (wr_acc && host_addr == ADDR_MODE) mode_q <= host_wdata[BYTE_W-1:0];
      if (acc && !host_we) begin
        if (host_addr == ADDR_DATA) begin
          sel_data_q <= 1'b1;
        end else begin
          sel_data_q <= 1'b0;
          reg_rd_q   <= reg_mux;
        end
      end
    end
  end

  assign host_rdata = sel_data_q ? xf_word : {{BYTE_W{1'b0}}, reg_rd_q};
  assign host_wait  = xf_busy;
  assign nand_ce_n  = ~mode_q[MODE_CE];
  assign nand_cle   = mode_q[MODE_CLE];
  assign nand_ale   = mode_q[MODE_ALE];

  nand_xfer_ctrl u_xfer (
    .clk       (clk),
    .rst       (rst),
    .go        (data_go),
    .go_read   (~host_we),
    .go_wide   (host_wide),
    .go_wdata  (host_wdata),
    .cyc_done  (cyc_done),
    .cyc_rbyte (cyc_rbyte),
    .cyc_start (cyc_start),
    .cyc_read  (cyc_read),
    .cyc_wbyte (cyc_wbyte),
    .busy      (xf_busy),
    .word      (xf_word)
  );

  nand_byte_cycle #(.STROBE_CLKS(STROBE_CLKS)) u_cycle (
    .clk     (clk),
    .rst     (rst),
    .start   (cyc_start),
    .is_read (cyc_read),
    .wbyte   (cyc_wbyte),
    .dq_in   (nand_dq_in),
    .we_n    (nand_we_n),
    .re_n    (nand_re_n),
    .dq_oe   (nand_dq_oe),
    .dq_out  (nand_dq_out),
    .rbyte   (cyc_rbyte),
    .done    (cyc_done)
  );

  nand_ready_irq #(.SYNC_STAGES(SYNC_STAGES)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .rb       (nand_rb),
    .clr_we   (wr_acc && host_addr == ADDR_ISR),
    .clr_bits (host_wdata[ISR_W-1:0]),
    .mask_we  (wr_acc && host_addr == ADDR_IMR),
    .mask_din (host_wdata[BYTE_W-1:0]),
    .busy     (rdy_busy),
    .isr      (isr),
    .mask     (imr),
    .irq      (host_irq)
  );
endmodule

// File: rtl/nand_host_bridge_chk.sv
module nand_host_bridge_chk (
  input logic clk,
  input logic rst,
  input logic host_wait,
  input logic nand_we_n,
  input logic nand_re_n,
  input logic nand_dq_oe,
  input logic nand_cle,
  input logic nand_ale,
  input logic nand_ce_n
);
  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(!nand_we_n && !nand_re_n)); // R3
  AST_WE_DRIVES_BUS: assert property (@(posedge clk) disable iff (rst)
    !nand_we_n |-> nand_dq_oe); // R3
  AST_OE_INSIDE_XFER: assert property (@(posedge clk) disable iff (rst)
    nand_dq_oe |-> host_wait); // R3
  AST_STROBE_STALLS: assert property (@(posedge clk) disable iff (rst)
    (!nand_we_n || !nand_re_n) |-> host_wait); // R7
  AST_LATCH_STABLE: assert property (@(posedge clk) disable iff (rst)
    host_wait |=> $stable({nand_cle, nand_ale, nand_ce_n})); // R7
endmodule

bind nand_host_bridge nand_host_bridge_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_wait  (host_wait),
  .nand_we_n  (nand_we_n),
  .nand_re_n  (nand_re_n),
  .nand_dq_oe (nand_dq_oe),
  .nand_cle   (nand_cle),
  .nand_ale   (nand_ale),
  .nand_ce_n  (nand_ce_n)
);

// File: tb/nand_host_bridge_test.sv
module nand_host_bridge_test;
  localparam int STROBE = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req = 1'b0, host_we = 1'b0, host_wide = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        host_wait, host_irq;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_out;
  logic [7:0]  nand_dq_in = '0;
  logic        nand_rb = 1'b1;

  int checks = 0;
  int failures = 0;
  bit done_flag = 0;

  logic [9:0] wr_exp[$];
  logic [7:0] rd_src[$];

  always #4 clk = ~clk;

  nand_host_bridge #(.STROBE_CLKS(STROBE), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we), .host_wide(host_wide),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_wait(host_wait), .host_irq(host_irq), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in),
    .nand_rb(nand_rb)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Driver: one request pulse, then wait for completion
  task automatic host_op(input logic [2:0] a, input logic we, input logic wide, input logic [15:0] d);
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_wide = wide; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_req = 1'b0;
    while (host_wait) @(negedge clk);
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [15:0] d);
    host_op(a, 1'b0, 1'b0, 16'h0);
    d = host_rdata;
  endtask

  // Device model: supply next byte as read strobe falls
  always @(negedge nand_re_n) if (rd_src.size() > 0) nand_dq_in <= rd_src.pop_front();

  // Monitor: strobe width, bus drive and byte order against the scoreboard
  int   low_cnt = 0;
  logic prev_we = 1'b1;
  logic prev_oe = 1'b0;
  logic [9:0] cap;
  always @(negedge clk) begin
    if (!rst) begin
      if (!nand_we_n) begin
        if (prev_we) chk(prev_oe, "R3 setup drive", prev_oe, 1);
        low_cnt++;
        cap = {nand_cle, nand_ale, nand_dq_out};
      end else if (!prev_we) begin
        chk(low_cnt == STROBE, "R3 strobe width", low_cnt, STROBE);
        chk(nand_dq_oe, "R3 hold drive", nand_dq_oe, 1);
        if (wr_exp.size() == 0) chk(1'b0, "R4/R5 unexpected write cycle", cap, 0);
        else begin
          logic [9:0] e;
          e = wr_exp.pop_front();
          chk(cap == e, "R3/R4 written byte and latches", cap, e);
        end
        low_cnt = 0;
      end
      prev_we = nand_we_n;
      prev_oe = nand_dq_oe;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      chk(1'b0, "watchdog", 0, 1);
      report();
    end
  end

  initial begin
    logic [15:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(nand_ce_n == 1 && nand_cle == 0 && nand_ale == 0, "R1 latch lines", {nand_ce_n, nand_cle, nand_ale}, 3'b100);
    chk(nand_we_n && nand_re_n && !nand_dq_oe, "R1 strobes", {nand_we_n, nand_re_n, nand_dq_oe}, 3'b110);
    chk(!host_wait && !host_irq, "R1 wait/irq", {host_wait, host_irq}, 0);
    reg_rd(3'd4, d);
    chk(d == 16'h0000, "R1 mode reset", d, 0);

    // R2 mode decode
    host_op(3'd4, 1, 0, 16'h0095);
    chk(!nand_ce_n && nand_cle && !nand_ale, "R2 command mode", {nand_ce_n, nand_cle, nand_ale}, 3'b010);
    wr_exp.push_back({2'b10, 8'h70});
    host_op(3'd0, 1, 0, 16'hAA70);            // R4 single command byte
    host_op(3'd4, 1, 0, 16'h0096);
    chk(!nand_ce_n && !nand_cle && nand_ale, "R2 address mode", {nand_ce_n, nand_cle, nand_ale}, 3'b001);
    reg_rd(3'd4, d);
    chk(d == 16'h0096, "R2 mode readback", d, 16'h0096);
    wr_exp.push_back({2'b01, 8'h3C});
    host_op(3'd0, 1, 0, 16'h553C);            // R4 single address byte

    // R3 wide write, low byte first
    host_op(3'd4, 1, 0, 16'h0094);
    wr_exp.push_back({2'b00, 8'hEF});
    wr_exp.push_back({2'b00, 8'hBE});
    host_op(3'd0, 1, 1, 16'hBEEF);
    chk(wr_exp.size() == 0, "R3 both bytes written", wr_exp.size(), 0);

    // R7 request during wait is ignored
    wr_exp.push_back({2'b00, 8'h34});
    wr_exp.push_back({2'b00, 8'h12});
    @(negedge clk);
    host_req = 1; host_we = 1; host_wide = 1; host_addr = 3'd0; host_wdata = 16'h1234;
    @(negedge clk);
    host_req = 0;
    chk(host_wait, "R7 wait raised", host_wait, 1);
    @(negedge clk);
    host_req = 1; host_we = 1; host_wide = 0; host_addr = 3'd4; host_wdata = 16'h0000;
    @(negedge clk);
    host_req = 0;
    while (host_wait) @(negedge clk);
    reg_rd(3'd4, d);
    chk(d == 16'h0094, "R7 mode write during wait ignored", d, 16'h0094);
    chk(!nand_ce_n, "R7 chip stays enabled", nand_ce_n, 0);

    // R6 reads
    rd_src.push_back(8'h5A);
    rd_src.push_back(8'hC3);
    host_op(3'd0, 0, 1, 16'h0);
    chk(host_rdata == 16'hC35A, "R6 wide read order", host_rdata, 16'hC35A);
    rd_src.push_back(8'h7E);
    host_op(3'd0, 0, 0, 16'h0);
    chk(host_rdata == 16'h007E, "R6 narrow read", host_rdata, 16'h007E);

    // R5 write dropped with mode bit 7 clear
    host_op(3'd4, 1, 0, 16'h0014);
    @(negedge clk);
    host_req = 1; host_we = 1; host_wide = 1; host_addr = 3'd0; host_wdata = 16'hDEAD;
    @(negedge clk);
    host_req = 0;
    chk(!host_wait, "R5 no wait on dropped write", host_wait, 0);
    repeat (20) @(negedge clk);
    chk(nand_we_n, "R5 no strobe", nand_we_n, 1);

    // R8 busy status
    nand_rb = 0;
    repeat (4) @(negedge clk);
    reg_rd(3'd5, d);
    chk(d == 16'h0080, "R8 busy reads 0x80", d, 16'h0080);
    // R9 falling edge does not set status
    reg_rd(3'd6, d);
    chk(d == 16'h0000, "R9 no set on ready-to-busy", d, 0);
    nand_rb = 1;
    repeat (4) @(negedge clk);
    reg_rd(3'd5, d);
    chk(d == 16'h0000, "R8 ready reads 0x00", d, 0);
    reg_rd(3'd6, d);
    chk(d == 16'h0001, "R9 set on busy-to-ready", d, 1);
    chk(!host_irq, "R10 masked irq low", host_irq, 0);

    // R10 masking
    host_op(3'd7, 1, 0, 16'h0081);
    @(negedge clk);
    chk(host_irq, "R10 irq on unmask", host_irq, 1);
    host_op(3'd7, 1, 0, 16'h0000);
    @(negedge clk);
    chk(!host_irq, "R10 irq off when masked", host_irq, 0);
    host_op(3'd7, 1, 0, 16'h0081);
    repeat (3) @(negedge clk);
    chk(host_irq, "R10 irq held until cleared", host_irq, 1);
    host_op(3'd6, 1, 0, 16'h000F);
    @(negedge clk);
    chk(!host_irq, "R10 irq off after clear", host_irq, 0);
    reg_rd(3'd6, d);
    chk(d == 16'h0000, "R9 clear by 0x0F", d, 0);

    chk(wr_exp.size() == 0, "R4 no missing write cycles", wr_exp.size(), 0);
    done_flag = 1;
    report();
  end
endmodule